// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block collects up to 64 level-sensitive peripheral interrupt lines, grouped in banks of 32, and presents them to a processor core as two request outputs: a normal interrupt request and a fast interrupt request. Each line has an enable bit and a routing bit that sends it to one of the two outputs. Software can read three views of every bank: the raw line state, the lines now requesting a normal interrupt, and the lines now requesting a fast interrupt.

A table with one register per priority level names the source that owns that level and marks whether the entry is in use. A read-only summary register scans the table from level 0 upward. For each output it reports the first listed source that is pending, enabled and routed there, so an interrupt handler reaches the most urgent source with a single read.

A one-bit wake policy decides how the block leaves idle. With the bit clear, any raised line wakes the core. With it set, only enabled lines do. Access goes through a simple 32-bit word bus with a byte address: writes take effect on a clock edge and read data is combinational.

Top module: `prio_intc`

## Requirements
- R1: After reset every mask, routing, control and priority register reads 0, and irq_o, fiq_o and the summary register are 0.
- R2: The raw pending register of a bank shows the source inputs as sampled on the previous clock edge. Bank 0 (sources 0..31) is at byte offset 0x000 and bank 1 (sources 32..63) at 0x09C, with bit k meaning source 32*bank+k.
- R3: The mask register of a bank (0x004 for bank 0, 0x0A0 for bank 1) enables source k when bit k is 1. The normal pending register (0x010 and 0x0AC) equals raw & mask & ~route, and irq_o is the OR of all normal pending bits.
- R4: The route register of a bank (0x008 and 0x0A4) sends source k to the fast output when bit k is 1 and to the normal output when it is 0. The fast pending register (0x00C and 0x0A8) equals raw & mask & route, and fiq_o is the OR of all fast pending bits.
- R5: Writing 0 to a bank's mask register disables every source of that bank from the next cycle on, and the other bank is unaffected.
- R6: Priority register i is at 0x01C+4*i for i<32 and at 0x0B0+4*(i-32) for i from 32 to 63. Bit 31 is the in-use flag and bits 5:0 hold the source number. All other bits read 0.
- R7: The summary register at 0x018 reports the normal output in bit 31 (found) and bits 21:16 (source), and the fast output in bit 15 (found) and bits 5:0 (source). For each output, the in-use priority level with the lowest index whose source is eligible for that output wins. When no source qualifies, the fields for that output are 0.
- R8: Bit 0 of the control register at 0x014 selects the wake policy. With 0, wake_o = idle_i & (any raw bit). With 1, wake_o = idle_i & (any raw & mask bit).
- R9: Bus writes to the raw, normal pending, fast pending and summary registers, and writes with a nonzero byte-address bits 1:0, change no register.
- R10: Pending is level-sensitive: once a source input drops, its raw bit and any request it caused clear one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Synchronous active-low reset |
| src_i | input | NUM_SRC | Level-sensitive source lines |
| idle_i | input | 1 | Core is idle |
| bus_wr_i | input | 1 | Write strobe for the current address |
| bus_addr_i | input | 12 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i (combinational) |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |
| wake_o | output | 1 | Wake request to the idle core |

## Verification
On every cycle the assertions check several relations. A winning summary entry always names an eligible source and asserts the matching request output. A zero mask write leaves the bank silent. Writes to read-only locations leave the configuration intact. Wake never rises outside idle, and it never rises with the strict policy while nothing enabled is pending. Only the bench scenarios can show the rest: the address map of both banks, read-back of priority entries, and the winner among many competing sources as levels are invalidated, masked and rerouted. The bench sweeps every source through masked, normal and fast routing.

// File: rtl/prio_intc_pkg.sv
// Package: shared address map of the prioritized interrupt controller.
// Assumes word-aligned byte addresses; all constants are word indices
// (byte offset / 4) so the decoder compares bus_addr_i[11:2] directly.
package prio_intc_pkg;
    localparam int BANK_W      = 32;   // sources per bank
    localparam int BANK_STRIDE = 39;   // word index of bank 1 (byte 0x09C)
    localparam int OFS_RAW     = 0;    // per-bank offsets
    localparam int OFS_MASK    = 1;
    localparam int OFS_ROUTE   = 2;
    localparam int OFS_FASTP   = 3;
    localparam int OFS_NORMP   = 4;
    localparam int W_CTRL      = 5;    // byte 0x014
    localparam int W_SUMMARY   = 6;    // byte 0x018
    localparam int W_PRIO_LO   = 7;    // byte 0x01C, levels 0..31
    localparam int W_PRIO_HI   = 44;   // byte 0x0B0, levels 32..63
    localparam int ADDR_W      = 12;
    localparam int WORD_W      = ADDR_W - 2;
endpackage

// File: rtl/intc_bank.sv
// Module: one bank of 32 sources. Samples the level inputs, holds the
// enable (mask) and routing registers and forms the two pending views.
// Assumes the top decodes addresses and raises at most one write strobe.
module intc_bank #(
    parameter int BANK_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_n_i,
    input  logic [BANK_W-1:0] src_i,
    input  logic              wr_mask_i,
    input  logic              wr_route_i,
    input  logic [BANK_W-1:0] wdata_i,
    output logic [BANK_W-1:0] raw_o,
    output logic [BANK_W-1:0] mask_o,
    output logic [BANK_W-1:0] route_o,
    output logic [BANK_W-1:0] norm_pend_o,
    output logic [BANK_W-1:0] fast_pend_o
);
    logic [BANK_W-1:0] src_q;
    logic [BANK_W-1:0] mask_q;
    logic [BANK_W-1:0] route_q;

    // Sample the source levels and apply register writes.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            src_q   <= '0;
            mask_q  <= '0;
            route_q <= '0;
        end else begin
            src_q <= src_i;
            if (wr_mask_i)  mask_q  <= wdata_i;
            if (wr_route_i) route_q <= wdata_i;
        end
    end

    // Form the pending views from sampled levels, enables and routing.
    always_comb begin
        raw_o       = src_q;
        mask_o      = mask_q;
        route_o     = route_q;
        norm_pend_o = src_q & mask_q & ~route_q;
        fast_pend_o = src_q & mask_q & route_q;
    end

    AST_MASK_ZERO_SILENCES: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (wr_mask_i && wdata_i == '0) |=> (norm_pend_o == '0 && fast_pend_o == '0)); // R5
    AST_ROUTE_WRITE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        wr_route_i |=> (route_o == $past(wdata_i))); // R4
endmodule

// File: rtl/intc_prio_table.sv
// Module: per-level priority table and the winner scan. Each level holds
// an in-use flag and a source number; the scan returns, separately for
// the normal and fast outputs, the lowest in-use level whose source is
// eligible. Assumes NUM_SRC is a power of two so every number is valid.
module intc_prio_table #(
    parameter int NUM_SRC = 64,
    parameter int NUM_LVL = NUM_SRC,
    parameter int SRC_W   = $clog2(NUM_SRC),
    parameter int LVL_W   = $clog2(NUM_LVL)
) (
    input  logic               clk_i,
    input  logic               rst_n_i,
    input  logic               wr_en_i,
    input  logic [LVL_W-1:0]   wr_lvl_i,
    input  logic               wr_valid_i,
    input  logic [SRC_W-1:0]   wr_src_i,
    input  logic [LVL_W-1:0]   rd_lvl_i,
    output logic [31:0]        rd_data_o,
    input  logic [NUM_SRC-1:0] norm_elig_i,
    input  logic [NUM_SRC-1:0] fast_elig_i,
    output logic               norm_found_o,
    output logic [SRC_W-1:0]   norm_src_o,
    output logic               fast_found_o,
    output logic [SRC_W-1:0]   fast_src_o
);
    logic [NUM_LVL-1:0] vld_q;
    logic [SRC_W-1:0]   num_q [NUM_LVL];

    // Store a level entry on a decoded write.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            vld_q <= '0;
            for (int l = 0; l < NUM_LVL; l++) num_q[l] <= '0;
        end else if (wr_en_i) begin
            vld_q[wr_lvl_i] <= wr_valid_i;
            num_q[wr_lvl_i] <= wr_src_i;
        end
    end

    // Read back one level entry; unused bits are zero.
    always_comb begin
        rd_data_o             = '0;
        rd_data_o[31]         = vld_q[rd_lvl_i];
        rd_data_o[SRC_W-1:0]  = num_q[rd_lvl_i];
    end

    // Scan from the top level down so the lowest hit is the last written.
    always_comb begin
        norm_found_o = 1'b0;
        norm_src_o   = '0;
        fast_found_o = 1'b0;
        fast_src_o   = '0;
        for (int l = NUM_LVL - 1; l >= 0; l--) begin
            if (vld_q[l] && norm_elig_i[num_q[l]]) begin
                norm_found_o = 1'b1;
                norm_src_o   = num_q[l];
            end
            if (vld_q[l] && fast_elig_i[num_q[l]]) begin
                fast_found_o = 1'b1;
                fast_src_o   = num_q[l];
            end
        end
    end

    AST_NORM_WINNER_ELIGIBLE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        norm_found_o |-> norm_elig_i[norm_src_o]); // R7
    AST_FAST_WINNER_ELIGIBLE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        fast_found_o |-> fast_elig_i[fast_src_o]); // R7
endmodule

// File: rtl/prio_intc.sv
// Module: top of the prioritized interrupt controller. Decodes the word
// bus, instantiates one bank per 32 sources and the priority table,
// holds the wake-policy bit and drives the request and wake outputs.
// Assumes NUM_SRC is 32 or 64; reads are combinational, writes apply at
// the clock edge; accesses with nonzero address bits 1:0 are ignored.
module prio_intc
    import prio_intc_pkg::*;
#(
    parameter int NUM_SRC = 64
) (
    input  logic                clk_i,
    input  logic                rst_n_i,
    input  logic [NUM_SRC-1:0]  src_i,
    input  logic                idle_i,
    input  logic                bus_wr_i,
    input  logic [ADDR_W-1:0]   bus_addr_i,
    input  logic [31:0]         bus_wdata_i,
    output logic [31:0]         bus_rdata_o,
    output logic                irq_o,
    output logic                fiq_o,
    output logic                wake_o
);
    localparam int NUM_BANKS = NUM_SRC / BANK_W;
    localparam int SRC_W     = $clog2(NUM_SRC);
    localparam int LVL_W     = $clog2(NUM_SRC);
    localparam int LO_LVLS   = (NUM_SRC < BANK_W) ? NUM_SRC : BANK_W;
    localparam int HI_LVLS   = NUM_SRC - LO_LVLS;

    logic [WORD_W-1:0]  word;
    logic               aligned;
    logic               prio_hit;
    logic [LVL_W-1:0]   prio_lvl;
    logic               ctrl_q;
    logic [NUM_SRC-1:0] raw_all, mask_all, route_all, norm_all, fast_all;
    logic [NUM_BANKS-1:0] wr_mask, wr_route;
    logic [31:0]        prio_rd;
    logic [31:0]        summary;
    logic               norm_found, fast_found;
    logic [SRC_W-1:0]   norm_src, fast_src;
    logic               ro_write;

    assign word    = bus_addr_i[ADDR_W-1:2];
    assign aligned = (bus_addr_i[1:0] == 2'b00);

    // Map the word index onto a priority level, if it falls in a table range.
    always_comb begin
        prio_hit = 1'b0;
        prio_lvl = '0;
        if (word >= WORD_W'(W_PRIO_LO) && word < WORD_W'(W_PRIO_LO + LO_LVLS)) begin
            prio_hit = 1'b1;
            prio_lvl = LVL_W'(word - WORD_W'(W_PRIO_LO));
        end else if (HI_LVLS > 0 && word >= WORD_W'(W_PRIO_HI)
                     && word < WORD_W'(W_PRIO_HI + HI_LVLS)) begin
            prio_hit = 1'b1;
            prio_lvl = LVL_W'(word - WORD_W'(W_PRIO_HI) + WORD_W'(BANK_W));
        end
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assign wr_mask[b]  = bus_wr_i && aligned
                             && word == WORD_W'(b * BANK_STRIDE + OFS_MASK);
        assign wr_route[b] = bus_wr_i && aligned
                             && word == WORD_W'(b * BANK_STRIDE + OFS_ROUTE);

        intc_bank #(.BANK_W(BANK_W)) i_bank (
            .clk_i       (clk_i),
            .rst_n_i     (rst_n_i),
            .src_i       (src_i[b*BANK_W +: BANK_W]),
            .wr_mask_i   (wr_mask[b]),
            .wr_route_i  (wr_route[b]),
            .wdata_i     (bus_wdata_i[BANK_W-1:0]),
            .raw_o       (raw_all[b*BANK_W +: BANK_W]),
            .mask_o      (mask_all[b*BANK_W +: BANK_W]),
            .route_o     (route_all[b*BANK_W +: BANK_W]),
            .norm_pend_o (norm_all[b*BANK_W +: BANK_W]),
            .fast_pend_o (fast_all[b*BANK_W +: BANK_W])
        );
    end

    intc_prio_table #(
        .NUM_SRC (NUM_SRC),
        .NUM_LVL (NUM_SRC),
        .SRC_W   (SRC_W),
        .LVL_W   (LVL_W)
    ) i_prio (
        .clk_i        (clk_i),
        .rst_n_i      (rst_n_i),
        .wr_en_i      (bus_wr_i && aligned && prio_hit),
        .wr_lvl_i     (prio_lvl),
        .wr_valid_i   (bus_wdata_i[31]),
        .wr_src_i     (bus_wdata_i[SRC_W-1:0]),
        .rd_lvl_i     (prio_lvl),
        .rd_data_o    (prio_rd),
        .norm_elig_i  (norm_all),
        .fast_elig_i  (fast_all),
        .norm_found_o (norm_found),
        .norm_src_o   (norm_src),
        .fast_found_o (fast_found),
        .fast_src_o   (fast_src)
    );

    // Hold the wake-policy bit.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i)
            ctrl_q <= 1'b0;
        else if (bus_wr_i && aligned && word == WORD_W'(W_CTRL))
            ctrl_q <= bus_wdata_i[0];
    end

    // Pack the two scan winners into the summary word.
    always_comb begin
        summary            = '0;
        summary[31]        = norm_found;
        summary[16 +: SRC_W] = norm_src;
        summary[15]        = fast_found;
        summary[0 +: SRC_W]  = fast_src;
    end

    // Select read data for the addressed register.
    always_comb begin
        bus_rdata_o = '0;
        if (aligned) begin
            if (word == WORD_W'(W_CTRL))    bus_rdata_o = {31'b0, ctrl_q};
            if (word == WORD_W'(W_SUMMARY)) bus_rdata_o = summary;
            if (prio_hit)                   bus_rdata_o = prio_rd;
            for (int b = 0; b < NUM_BANKS; b++) begin
                if (word == WORD_W'(b * BANK_STRIDE + OFS_RAW))   bus_rdata_o = raw_all[b*BANK_W +: BANK_W];
                if (word == WORD_W'(b * BANK_STRIDE + OFS_MASK))  bus_rdata_o = mask_all[b*BANK_W +: BANK_W];
                if (word == WORD_W'(b * BANK_STRIDE + OFS_ROUTE)) bus_rdata_o = route_all[b*BANK_W +: BANK_W];
                if (word == WORD_W'(b * BANK_STRIDE + OFS_FASTP)) bus_rdata_o = fast_all[b*BANK_W +: BANK_W];
                if (word == WORD_W'(b * BANK_STRIDE + OFS_NORMP)) bus_rdata_o = norm_all[b*BANK_W +: BANK_W];
            end
        end
    end

    // Drive the request and wake outputs.
    always_comb begin
        irq_o  = |norm_all;
        fiq_o  = |fast_all;
        wake_o = idle_i && (ctrl_q ? |(raw_all & mask_all) : |raw_all);
    end

    // Flag a write aimed at a read-only location (assertion support only).
    always_comb begin
        ro_write = bus_wr_i && (!aligned || word == WORD_W'(W_SUMMARY));
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bus_wr_i && (word == WORD_W'(b * BANK_STRIDE + OFS_RAW)
                          || word == WORD_W'(b * BANK_STRIDE + OFS_FASTP)
                          || word == WORD_W'(b * BANK_STRIDE + OFS_NORMP)))
                ro_write = 1'b1;
        end
    end

    AST_RO_WRITE_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        ro_write |=> ($stable(mask_all) && $stable(route_all) && $stable(ctrl_q))); // R9
    AST_NO_WAKE_AWAKE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !idle_i |-> !wake_o); // R8
    AST_STRICT_WAKE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (ctrl_q && (raw_all & mask_all) == '0) |-> !wake_o); // R8
    AST_WINNER_RAISES_IRQ: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        norm_found |-> (irq_o && mask_all[norm_src] && raw_all[norm_src])); // R7
    AST_WINNER_RAISES_FIQ: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        fast_found |-> (fiq_o && route_all[fast_src])); // R7
endmodule

// File: tb/test_prio_intc.sv
module test_prio_intc;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] src = '0;
    logic        idle = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, fiq, wake;

    int errors = 0;
    int checks = 0;

    // Bench model, built from the requirements.
    logic [63:0] m_mask = '0, m_route = '0;
    logic        m_ctrl = 1'b0;
    bit          tv [64];
    int          ts [64];

    prio_intc #(.NUM_SRC(64)) i_prio_intc (
        .clk_i(clk), .rst_n_i(rst_n), .src_i(src), .idle_i(idle),
        .bus_wr_i(bus_wr), .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata),
        .bus_rdata_o(bus_rdata), .irq_o(irq), .fiq_o(fiq), .wake_o(wake)
    );

    always #4 clk = ~clk;

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [11:0] bank_addr(input int b, input int ofs);
        return (b == 0 ? 12'h000 : 12'h09C) + 12'(ofs);
    endfunction

    function automatic logic [11:0] prio_addr(input int l);
        return (l < 32) ? 12'(12'h01C + 4 * l) : 12'(12'h0B0 + 4 * (l - 32));
    endfunction

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        step();
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    function automatic logic [31:0] exp_summary();
        logic [31:0] r = '0;
        bit fn = 0, ff = 0;
        for (int l = 0; l < 64; l++) begin
            int s;
            s = ts[l];
            if (tv[l] && !fn && src[s] && m_mask[s] && !m_route[s]) begin
                fn = 1; r[31] = 1'b1; r[21:16] = s[5:0];
            end
            if (tv[l] && !ff && src[s] && m_mask[s] && m_route[s]) begin
                ff = 1; r[15] = 1'b1; r[5:0] = s[5:0];
            end
        end
        return r;
    endfunction

    task automatic chk_outputs(input string tag);
        logic exp_wake;
        exp_wake = idle && (m_ctrl ? |(src & m_mask) : |src);
        chk({tag, " irq_o"}, {31'b0, irq}, {31'b0, |(src & m_mask & ~m_route)});
        chk({tag, " fiq_o"}, {31'b0, fiq}, {31'b0, |(src & m_mask & m_route)});
        chk({tag, " wake_o"}, {31'b0, wake}, {31'b0, exp_wake});
    endtask

    task automatic chk_bank_views(input string tag, input int b);
        logic [31:0] d, s32, m32, r32;
        s32 = src[b*32 +: 32]; m32 = m_mask[b*32 +: 32]; r32 = m_route[b*32 +: 32];
        rd(bank_addr(b, 0), d);  chk({tag, " R2 raw"}, d, s32);
        rd(bank_addr(b, 16), d); chk({tag, " R3 normal pending"}, d, s32 & m32 & ~r32);
        rd(bank_addr(b, 12), d); chk({tag, " R4 fast pending"}, d, s32 & m32 & r32);
    endtask

    task automatic set_mask(input logic [63:0] v);
        wr(bank_addr(0, 4), v[31:0]);
        wr(bank_addr(1, 4), v[63:32]);
        m_mask = v;
    endtask

    task automatic set_route(input logic [63:0] v);
        wr(bank_addr(0, 8), v[31:0]);
        wr(bank_addr(1, 8), v[63:32]);
        m_route = v;
    endtask

    initial begin
        logic [31:0] d;
        for (int l = 0; l < 64; l++) begin tv[l] = 0; ts[l] = 0; end
        repeat (3) step();
        rst_n = 1'b1;

        // R1: reset state
        for (int b = 0; b < 2; b++) begin
            rd(bank_addr(b, 4), d); chk("R1 mask reset", d, 32'h0);
            rd(bank_addr(b, 8), d); chk("R1 route reset", d, 32'h0);
        end
        rd(12'h014, d); chk("R1 control reset", d, 32'h0);
        rd(12'h018, d); chk("R1 summary reset", d, 32'h0);
        for (int l = 0; l < 64; l += 21) begin
            rd(prio_addr(l), d); chk("R1 priority reset", d, 32'h0);
        end
        chk("R1 irq_o reset", {31'b0, irq}, 32'h0);
        chk("R1 fiq_o reset", {31'b0, fiq}, 32'h0);

        // R6: fill the table, level l names source 63-l, junk in unused bits
        for (int l = 0; l < 64; l++) begin
            wr(prio_addr(l), 32'hFFFF_FFC0 | 32'(63 - l));
            tv[l] = 1; ts[l] = 63 - l;
        end
        for (int l = 0; l < 64; l++) begin
            rd(prio_addr(l), d); chk("R6 priority readback", d, 32'h8000_0000 | 32'(63 - l));
        end

        // R2/R3/R8: every source alone, all masked, idle, lax wake policy
        idle = 1'b1;
        for (int s = 0; s < 64; s++) begin
            src = 64'd1 << s;
            step();
            chk_bank_views("sweep masked", s / 32);
            chk_outputs("R3 R8 sweep masked");
        end

        // R3/R7: enabled, normal routing
        set_mask('1);
        for (int s = 0; s < 64; s++) begin
            src = 64'd1 << s;
            step();
            chk_bank_views("sweep normal", s / 32);
            chk_outputs("R3 sweep normal");
            rd(12'h018, d); chk("R7 summary single normal", d, exp_summary());
        end

        // R4/R7: enabled, fast routing
        set_route('1);
        for (int s = 0; s < 64; s++) begin
            src = 64'd1 << s;
            step();
            chk_bank_views("sweep fast", s / 32);
            chk_outputs("R4 sweep fast");
            rd(12'h018, d); chk("R7 summary single fast", d, exp_summary());
        end

        // R7: contest among all sources
        set_route('0);
        src = '1;
        step();
        rd(12'h018, d); chk("R7 contest all pending", d, exp_summary());
        chk("R7 contest expected winner", d, 32'h803F_0000);
        wr(prio_addr(0), 32'h0); tv[0] = 0;
        rd(12'h018, d); chk("R7 invalid level skipped", d, exp_summary());
        set_mask(m_mask & ~(64'd1 << 62));
        rd(12'h018, d); chk("R7 masked source skipped", d, exp_summary());
        set_route(64'd1 << 61);
        rd(12'h018, d); chk("R7 split normal and fast winners", d, exp_summary());
        chk("R7 split expected", d, 32'h803C_803D);
        chk_outputs("R4 contest");

        // R5: zero mask write silences bank 0 only
        wr(bank_addr(0, 4), 32'h0); m_mask[31:0] = '0;
        chk_bank_views("R5 bank0 after clear", 0);
        chk_bank_views("R5 bank1 untouched", 1);
        rd(bank_addr(0, 4), d); chk("R5 mask reads zero", d, 32'h0);
        rd(bank_addr(1, 4), d); chk("R5 bank1 mask kept", d, m_mask[63:32]);

        // R9: writes to read-only and unaligned locations
        wr(12'h000, '1); wr(12'h00C, '1); wr(12'h010, '1); wr(12'h018, '1);
        wr(12'h09C, '1); wr(12'h0A8, '1); wr(12'h0AC, '1);
        wr(12'h005, '1); wr(12'h0A1, 32'h0); wr(12'h015, '1);
        for (int b = 0; b < 2; b++) begin
            rd(bank_addr(b, 4), d); chk("R9 mask unchanged", d, m_mask[b*32 +: 32]);
            rd(bank_addr(b, 8), d); chk("R9 route unchanged", d, m_route[b*32 +: 32]);
            chk_bank_views("R9 views unchanged", b);
        end
        rd(12'h014, d); chk("R9 control unchanged", d, 32'h0);
        rd(12'h018, d); chk("R9 summary unchanged", d, exp_summary());

        // R8: strict wake policy
        wr(12'h014, 32'h1); m_ctrl = 1'b1;
        rd(12'h014, d); chk("R8 control readback", d, 32'h1);
        set_mask('0);
        src = 64'hF0F0_0000_0000_0F0F;
        step();
        chk_outputs("R8 strict masked");
        set_mask(64'd1 << 40);
        chk_outputs("R8 strict enabled");
        idle = 1'b0;
        step();
        chk_outputs("R8 not idle");
        idle = 1'b1;
        wr(12'h014, 32'h0); m_ctrl = 1'b0;
        set_mask('0);
        chk_outputs("R8 lax masked");

        // R10: level drop clears everything one cycle later
        set_mask('1); set_route(64'h0000_FFFF_0000_FFFF);
        src = '1;
        step();
        chk_outputs("R10 before drop");
        src = '0;
        step();
        chk_outputs("R10 after drop");
        chk_bank_views("R10 after drop", 0);
        chk_bank_views("R10 after drop", 1);
        rd(12'h018, d); chk("R10 summary after drop", d, 32'h0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule